// File: doc/BRIEF.md
# Register-Mapped Signed Divider

This block is a small signed division engine that a processor reaches through a 32-bit register port. Software loads a divisor, then starts a division by writing a dividend. Two start paths exist. A 32-bit dividend written to its own register starts a 32/32 divide. A 64-bit dividend is built from a high word that sits in one register, and writing the low word to the next register starts a 64/32 divide. The results land in two pairs of registers. Each pair holds the remainder in one register and the quotient in the other, and both pairs carry the same values.

The datapath is sequential. It runs a restoring divide on magnitudes and produces one quotient bit per clock. A sign and saturation stage then builds the final values. While the engine iterates, `busy` is high, the port ignores writes, and the result copy registers keep their previous contents. A zero divisor and a quotient that does not fit in 32 bits each give fixed results rather than undefined ones.

Top module: `sdiv_regblock`

## Requirements
- R1: After reset every register reads 0 and `busy` is low.
- R2: While idle, writes to byte offsets 0x00, 0x10, 0x18 and 0x1C store the word and reads return it. Offsets 0x08 and 0x0C, and any offset whose two low bits are non-zero, read 0 and ignore writes.
- R3: With a non-zero divisor at 0x00, a write to 0x04 starts a 32/32 signed divide of that word. The quotient truncates toward zero and the remainder carries the dividend's sign. The remainder goes to 0x10 and 0x18, and the quotient goes to 0x14 and 0x1C.
- R4: With a non-zero divisor, a write to 0x14 starts a 64/32 signed divide of the dividend {0x10 contents, written word}. The rounding and the result placement are the same as in R3.
- R5: A 64/32 quotient above 0x7FFFFFFF is replaced in 0x14 and 0x1C by 0x7FFFFFFF. One below -2^31 is replaced by 0x80000000. The remainder is still the true remainder.
- R6: A 32/32 divide of 0x80000000 by -1 gives quotient 0x7FFFFFFF and remainder 0.
- R7: A write to 0x04 while the divisor is 0 clears 0x10, 0x14, 0x18 and 0x1C on the next clock, and `busy` stays low.
- R8: A write to 0x14 while the divisor is 0 stores the word in 0x14 and starts nothing. `busy` stays low, and 0x10, 0x18 and 0x1C keep their values.
- R9: After a starting write, `busy` is high for exactly 2*DW+1 cycles. Results appear when it falls, and until then 0x18 and 0x1C read their previous values.
- R10: Any write while `busy` is high is ignored. This includes start writes and divisor writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the addressed register |
| addr | input | AW (5) | Byte offset of the register |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data of the addressed register, combinational |
| busy | output | 1 | Division in progress |

## Verification
The assertions assume that software starts a division only while `busy` is low. A write during `busy` is dropped, so the assertions treat it as a non-event. They also assume that the divisor register does not change under a running job, and the design enforces this through R10. The bench always waits for `busy` to fall before it checks results. It issues writes during `busy` only in the scenario that checks they are dropped. It keeps 64-bit dividends away from -2^63 divided by -1, so the bench's own 64-bit reference arithmetic stays defined.

// File: rtl/sdiv_pkg.sv
package sdiv_pkg;
    localparam int SDIV_DW = 32;
    localparam int SDIV_AW = 5;

    // word indices inside the register window (byte offset / 4)
    localparam int WI_DVSR  = 0;
    localparam int WI_DVD32 = 1;
    localparam int WI_HIREM = 4;
    localparam int WI_LOQUO = 5;
    localparam int WI_REMC  = 6;
    localparam int WI_QUOC  = 7;

    typedef struct packed {
        logic neg_quo;
        logic neg_rem;
    } sign_t;

    typedef enum logic [1:0] {
        ACT_NONE,
        ACT_START,
        ACT_CLEAR,
        ACT_STORE_ONLY
    } wr_act_e;
endpackage

// File: rtl/sdiv_iter.sv
module sdiv_iter #(
    parameter int DW = sdiv_pkg::SDIV_DW
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [2*DW-1:0] dvd_mag,
    input  logic [DW-1:0]   dvs_mag,
    output logic            running,
    output logic            done,
    output logic [2*DW-1:0] q_mag,
    output logic [DW-1:0]   r_mag
);
    localparam int XW = 2 * DW;
    localparam int CW = $clog2(XW + 1);

    logic [XW-1:0] sh_q;
    logic [DW-1:0] rem_q;
    logic [DW-1:0] dvs_q;
    logic [CW-1:0] cnt_q;
    logic [DW:0]   trial;
    logic [DW:0]   diff;
    logic          fits;

    always_comb begin
        trial = {rem_q, sh_q[XW-1]};
        diff  = trial - {1'b0, dvs_q};
        fits  = trial >= {1'b0, dvs_q};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sh_q    <= '0;
            rem_q   <= '0;
            dvs_q   <= '0;
            cnt_q   <= '0;
            running <= 1'b0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            if (load) begin
                sh_q    <= dvd_mag;
                rem_q   <= '0;
                dvs_q   <= dvs_mag;
                cnt_q   <= CW'(XW);
                running <= 1'b1;
            end else if (running) begin
                rem_q <= fits ? diff[DW-1:0] : trial[DW-1:0];
                sh_q  <= {sh_q[XW-2:0], fits};
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    running <= 1'b0;
                    done    <= 1'b1;
                end
            end
        end
    end

    assign q_mag = sh_q;
    assign r_mag = rem_q;
endmodule

// File: rtl/sdiv_post.sv
module sdiv_post #(
    parameter int DW = sdiv_pkg::SDIV_DW
) (
    input  logic [2*DW-1:0] q_mag,
    input  logic [DW-1:0]   r_mag,
    input  sdiv_pkg::sign_t sgn,
    output logic [DW-1:0]   quo,
    output logic [DW-1:0]   rem
);
    localparam logic [2*DW-1:0] POS_LIM = {{(DW+1){1'b0}}, {(DW-1){1'b1}}};
    localparam logic [2*DW-1:0] NEG_LIM = POS_LIM + 1'b1;
    localparam logic [DW-1:0]   SAT_POS = {1'b0, {(DW-1){1'b1}}};
    localparam logic [DW-1:0]   SAT_NEG = {1'b1, {(DW-1){1'b0}}};

    always_comb begin
        if (!sgn.neg_quo && q_mag > POS_LIM)
            quo = SAT_POS;
        else if (sgn.neg_quo && q_mag > NEG_LIM)
            quo = SAT_NEG;
        else if (sgn.neg_quo)
            quo = -q_mag[DW-1:0];
        else
            quo = q_mag[DW-1:0];
        rem = sgn.neg_rem ? -r_mag : r_mag;
    end
endmodule

// File: rtl/sdiv_regblock.sv
module sdiv_regblock #(
    parameter int DW = sdiv_pkg::SDIV_DW,
    parameter int AW = sdiv_pkg::SDIV_AW
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata,
    output logic          busy
);
    import sdiv_pkg::*;

    localparam int IW = AW - 2;
    localparam int XW = 2 * DW;

    logic [DW-1:0] dvsr_q, dvd32_q, hi_q, lo_q, remc_q, quoc_q;
    sign_t         sgn_q;
    logic [IW-1:0] idx;
    logic          aligned;
    logic          wr_ok;
    wr_act_e       act;
    logic [XW-1:0] dvd_full;
    logic [XW-1:0] dvd_mag;
    logic [DW-1:0] dvs_mag;
    logic          it_run, it_done;
    logic [XW-1:0] q_mag;
    logic [DW-1:0] r_mag;
    logic [DW-1:0] quo, rem;

    assign idx     = addr[AW-1:2];
    assign aligned = (addr[1:0] == 2'b00);
    assign busy    = it_run | it_done;
    assign wr_ok   = wr_en & aligned & ~busy;

    always_comb begin
        act      = ACT_NONE;
        dvd_full = {hi_q, wdata};
        if (wr_ok && idx == IW'(WI_DVD32)) begin
            dvd_full = {{DW{wdata[DW-1]}}, wdata};
            act      = (dvsr_q == '0) ? ACT_CLEAR : ACT_START;
        end else if (wr_ok && idx == IW'(WI_LOQUO)) begin
            act = (dvsr_q == '0) ? ACT_STORE_ONLY : ACT_START;
        end
        dvd_mag = dvd_full[XW-1] ? -dvd_full : dvd_full;
        dvs_mag = dvsr_q[DW-1] ? -dvsr_q : dvsr_q;
    end

    sdiv_iter #(.DW(DW)) u_iter (
        .clk     (clk),
        .rst     (rst),
        .load    (act == ACT_START),
        .dvd_mag (dvd_mag),
        .dvs_mag (dvs_mag),
        .running (it_run),
        .done    (it_done),
        .q_mag   (q_mag),
        .r_mag   (r_mag)
    );

    sdiv_post #(.DW(DW)) u_post (
        .q_mag (q_mag),
        .r_mag (r_mag),
        .sgn   (sgn_q),
        .quo   (quo),
        .rem   (rem)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            dvsr_q  <= '0;
            dvd32_q <= '0;
            hi_q    <= '0;
            lo_q    <= '0;
            remc_q  <= '0;
            quoc_q  <= '0;
            sgn_q   <= '0;
        end else if (it_done) begin
            hi_q   <= rem;
            remc_q <= rem;
            lo_q   <= quo;
            quoc_q <= quo;
        end else if (wr_ok) begin
            if (act == ACT_START) begin
                sgn_q.neg_quo <= dvd_full[XW-1] ^ dvsr_q[DW-1];
                sgn_q.neg_rem <= dvd_full[XW-1];
            end
            if (act == ACT_CLEAR) begin
                hi_q   <= '0;
                lo_q   <= '0;
                remc_q <= '0;
                quoc_q <= '0;
            end
            if (idx == IW'(WI_DVSR))  dvsr_q  <= wdata;
            if (idx == IW'(WI_DVD32)) dvd32_q <= wdata;
            if (idx == IW'(WI_HIREM)) hi_q    <= wdata;
            if (idx == IW'(WI_LOQUO)) lo_q    <= wdata;
            if (idx == IW'(WI_REMC))  remc_q  <= wdata;
            if (idx == IW'(WI_QUOC))  quoc_q  <= wdata;
        end
    end

    always_comb begin
        rdata = '0;
        if (aligned) begin
            if (idx == IW'(WI_DVSR))  rdata = dvsr_q;
            if (idx == IW'(WI_DVD32)) rdata = dvd32_q;
            if (idx == IW'(WI_HIREM)) rdata = hi_q;
            if (idx == IW'(WI_LOQUO)) rdata = lo_q;
            if (idx == IW'(WI_REMC))  rdata = remc_q;
            if (idx == IW'(WI_QUOC))  rdata = quoc_q;
        end
    end
endmodule

// File: rtl/sdiv_chk.sv
module sdiv_chk #(
    parameter int DW = sdiv_pkg::SDIV_DW,
    parameter int AW = sdiv_pkg::SDIV_AW
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic [AW-1:0] addr,
    input logic          busy,
    input logic          it_done,
    input logic [DW-1:0] dvsr_q,
    input logic [DW-1:0] hi_q,
    input logic [DW-1:0] lo_q,
    input logic [DW-1:0] remc_q,
    input logic [DW-1:0] quoc_q
);
    localparam int LAT = 2 * DW + 1;
    localparam int CW  = $clog2(LAT + 2);

    logic [CW-1:0] run_cnt;
    logic          st32, st64;

    assign st32 = wr_en && !busy && addr == AW'(4);
    assign st64 = wr_en && !busy && addr == AW'(20);

    always_ff @(posedge clk) begin
        if (rst || !busy) run_cnt <= '0;
        else if (run_cnt != '1) run_cnt <= run_cnt + 1'b1;
    end

    // R3 / R4: a start with a non-zero divisor raises busy
    a_r3_start_busy: assert property (@(posedge clk) disable iff (rst)
        ((st32 || st64) && dvsr_q != '0) |=> busy);

    // R7: zero-divisor 32/32 start clears all results and stays idle
    a_r7_zero_clear: assert property (@(posedge clk) disable iff (rst)
        (st32 && dvsr_q == '0) |=> (!busy && hi_q == '0 && lo_q == '0
                                    && remc_q == '0 && quoc_q == '0));

    // R8: zero-divisor 64/32 start keeps results and stays idle
    a_r8_zero_keep: assert property (@(posedge clk) disable iff (rst)
        (st64 && dvsr_q == '0) |=> (!busy && $stable(hi_q)
                                    && $stable(remc_q) && $stable(quoc_q)));

    // R9: result copies hold while iterating
    a_r9_hold_copies: assert property (@(posedge clk) disable iff (rst)
        (busy && !it_done) |=> ($stable(remc_q) && $stable(quoc_q)));

    // R9: busy never exceeds its fixed length
    a_r9_busy_len: assert property (@(posedge clk) disable iff (rst)
        busy |-> (run_cnt < CW'(LAT)));

    // R10: the divisor cannot change under a running job
    a_r10_dvsr_locked: assert property (@(posedge clk) disable iff (rst)
        (busy && !it_done) |=> $stable(dvsr_q));

    // R3 / R4: both pairs agree when a job ends
    a_r4_pairs_equal: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (hi_q == remc_q && lo_q == quoc_q));
endmodule

bind sdiv_regblock sdiv_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en),
    .addr    (addr),
    .busy    (busy),
    .it_done (it_done),
    .dvsr_q  (dvsr_q),
    .hi_q    (hi_q),
    .lo_q    (lo_q),
    .remc_q  (remc_q),
    .quoc_q  (quoc_q)
);

// File: tb/test_sdiv_regblock.sv
module test_sdiv_regblock;
    localparam int DW  = 32;
    localparam int AW  = 5;
    localparam int LAT = 2 * DW + 1;

    logic          clk = 1'b0;
    logic          rst;
    logic          wr_en;
    logic [AW-1:0] addr;
    logic [DW-1:0] wdata;
    logic [DW-1:0] rdata;
    logic          busy;

    int total = 0;
    int bad   = 0;
    bit hung  = 0;

    always #5 clk = ~clk;

    sdiv_regblock #(.DW(DW), .AW(AW)) i_sdiv_regblock (
        .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .busy(busy)
    );

    task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [DW-1:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic wait_idle(output int n);
        n = 0;
        while (busy && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    function automatic void model(input longint a, input longint b,
                                  output logic [DW-1:0] q, output logic [DW-1:0] r);
        longint qq, rr;
        qq = a / b;
        rr = a % b;
        if (qq > 64'sh7FFFFFFF)       q = 32'h7FFFFFFF;
        else if (qq < -64'sh80000000) q = 32'h80000000;
        else                          q = qq[31:0];
        r = rr[31:0];
    endfunction

    task automatic check_results(input string tag, input logic [DW-1:0] q, input logic [DW-1:0] r);
        logic [DW-1:0] v;
        rd(5'h10, v); chk({tag, " rem@10"}, v, r);
        rd(5'h18, v); chk({tag, " rem@18"}, v, r);
        rd(5'h14, v); chk({tag, " quo@14"}, v, q);
        rd(5'h1C, v); chk({tag, " quo@1C"}, v, q);
    endtask

    // R3, R6, R9
    task automatic t_div32(input string tag, input logic [DW-1:0] a, input logic [DW-1:0] b);
        logic [DW-1:0] q, r, old_q, v;
        int n;
        model(longint'($signed(a)), longint'($signed(b)), q, r);
        wr(5'h00, b);
        rd(5'h1C, old_q);
        wr(5'h04, a);
        rd(5'h1C, v);
        chk({tag, " R9 copy held"}, v, old_q);
        wait_idle(n);
        chk({tag, " R9 busy length"}, n, LAT);
        check_results(tag, q, r);
    endtask

    // R4, R5
    task automatic t_div64(input string tag, input logic [DW-1:0] hi, input logic [DW-1:0] lo,
                           input logic [DW-1:0] b);
        logic [DW-1:0] q, r;
        int n;
        model($signed({hi, lo}), longint'($signed(b)), q, r);
        wr(5'h00, b);
        wr(5'h10, hi);
        wr(5'h14, lo);
        wait_idle(n);
        chk({tag, " R9 busy length"}, n, LAT);
        check_results(tag, q, r);
    endtask

    // R1
    task automatic t_reset();
        logic [DW-1:0] v;
        chk("R1 busy", busy, 0);
        for (int i = 0; i < 8; i++) begin
            rd(AW'(i * 4), v);
            chk("R1 reg zero", v, 0);
        end
    endtask

    // R2
    task automatic t_regs();
        logic [DW-1:0] v;
        wr(5'h00, 32'h1234_5678); rd(5'h00, v); chk("R2 dvsr rw", v, 32'h1234_5678);
        wr(5'h10, 32'hA5A5_0001); rd(5'h10, v); chk("R2 hi rw", v, 32'hA5A5_0001);
        wr(5'h18, 32'h0BAD_F00D); rd(5'h18, v); chk("R2 remc rw", v, 32'h0BAD_F00D);
        wr(5'h1C, 32'hCAFE_0002); rd(5'h1C, v); chk("R2 quoc rw", v, 32'hCAFE_0002);
        wr(5'h08, 32'hFFFF_FFFF); rd(5'h08, v); chk("R2 hole 08", v, 0);
        wr(5'h0C, 32'hFFFF_FFFF); rd(5'h0C, v); chk("R2 hole 0C", v, 0);
        wr(5'h01, 32'hFFFF_FFFF); rd(5'h00, v); chk("R2 misaligned ignored", v, 32'h1234_5678);
        rd(5'h01, v); chk("R2 misaligned read", v, 0);
        chk("R2 no start", busy, 0);
    endtask

    // R7
    task automatic t_zero32();
        logic [DW-1:0] v;
        t_div32("R3 prefill", 32'd1000, 32'd7);
        wr(5'h00, 32'd0);
        wr(5'h04, 32'd55);
        chk("R7 busy low", busy, 0);
        check_results("R7 cleared", 0, 0);
        rd(5'h04, v); chk("R7 dividend stored", v, 32'd55);
    endtask

    // R8
    task automatic t_zero64();
        logic [DW-1:0] v;
        t_div32("R3 prefill2", 32'd1000, 32'd7);
        wr(5'h00, 32'd0);
        wr(5'h14, 32'h7777_0000);
        chk("R8 busy low", busy, 0);
        rd(5'h10, v); chk("R8 hi kept", v, 32'd6);
        rd(5'h18, v); chk("R8 remc kept", v, 32'd6);
        rd(5'h1C, v); chk("R8 quoc kept", v, 32'd142);
        rd(5'h14, v); chk("R8 lo stored", v, 32'h7777_0000);
    endtask

    // R10
    task automatic t_busy_write();
        logic [DW-1:0] v;
        int n;
        wr(5'h00, 32'd9);
        wr(5'h04, 32'd100);
        wr(5'h00, 32'd3);
        wr(5'h04, 32'd7);
        wr(5'h1C, 32'hDEAD_BEEF);
        wait_idle(n);
        rd(5'h00, v); chk("R10 dvsr unchanged", v, 32'd9);
        rd(5'h04, v); chk("R10 dvd unchanged", v, 32'd100);
        check_results("R10 job intact", 32'd11, 32'd1);
    endtask

    initial begin
        wr_en = 1'b0; addr = '0; wdata = '0; rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_regs();
        t_div32("R3 7/2",   32'd7, 32'd2);
        t_div32("R3 -7/2",  -32'sd7, 32'd2);
        t_div32("R3 7/-2",  32'd7, -32'sd2);
        t_div32("R3 -7/-2", -32'sd7, -32'sd2);
        t_div32("R3 0/5",   32'd0, 32'd5);
        t_div32("R3 min/1", 32'h8000_0000, 32'd1);
        t_div32("R3 x/min", 32'd12345, 32'h8000_0000);
        t_div32("R6 min/-1", 32'h8000_0000, 32'hFFFF_FFFF);
        t_div64("R4 pos",   32'h0000_0001, 32'h0000_0000, 32'd3);
        t_div64("R4 neg",   32'hFFFF_FFFF, 32'h0000_0001, 32'd1000);
        t_div64("R4 negdiv", 32'h0000_0000, 32'h7FFF_FFFF, -32'sd16);
        t_div64("R5 pos sat", 32'h0000_0010, 32'h0000_0000, 32'd2);
        t_div64("R5 neg sat", 32'h0000_0010, 32'h0000_0000, -32'sd2);
        t_div64("R5 edge neg", 32'hFFFF_FFFF, 32'h8000_0000, 32'd1);
        t_zero32();
        t_zero64();
        t_busy_write();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        hung = 1;
        total++;
        bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule